// File: doc/BRIEF.md
# Per-Timeslot Loopback Switch

This block sits between the system-side byte stream and the line-side framer of a 32-slot E1 link. On every slot strobe it receives one system transmit byte and one line receive byte, both tagged with the slot index. One clock later it presents a byte toward the system output and a byte toward the line. The block has no serialiser, no framing logic and no line coder.

Each slot has its own control word. One bit in that word turns the slot around toward the system side (local loop), and another bit turns it around toward the far end (remote loop). A single global register holds four frame-wide loop modes. When any of these modes is active, it overrides the per-slot choices. All control words are loaded through a plain address, data and write-enable port.

Top module: `tslot_loop_switch`

## Requirements
- R1: After reset, `out_valid`, `sys_rx_byte` and `line_tx_byte` are 0, and every per-slot and global loop bit is 0, so slots pass through unchanged.
- R2: With no loop active, a strobed slot gives `sys_rx_byte` = `line_rx_byte` and `line_tx_byte` = `sys_tx_byte`, and `out_slot` = `slot_idx`. All of these appear one clock after the strobe.
- R3: Register addresses 0 to 31 hold the per-slot words. When bit 5 of a slot's word is 1 (local loop), that slot's `sys_tx_byte` replaces the received byte on `sys_rx_byte`.
- R4: When bit 4 of a slot's word is 1 (remote loop), that slot's `line_rx_byte` replaces the system byte on `line_tx_byte`.
- R5: Local and remote loop on the same slot act independently. With both set, `sys_rx_byte` = `sys_tx_byte` and `line_tx_byte` = `line_rx_byte`.
- R6: Bits 7, 6 and 3 to 0 of a per-slot word have no effect on routing. Writes to addresses 33 to 63 change nothing.
- R7: Address 32 is the global register. When its bit 3 (digital loop) is set, every slot gives `sys_rx_byte` = `sys_tx_byte` and `line_tx_byte` = `sys_tx_byte`.
- R8: When global bit 2 (remote loop) is set, every slot gives `line_tx_byte` = `line_rx_byte` and `sys_rx_byte` = `line_rx_byte`.
- R9: When global bit 1 (system-bus loop) is set, every slot gives `sys_rx_byte` = `sys_tx_byte`, and `line_tx_byte` carries the idle byte 0xFF.
- R10: When global bit 0 (payload loop) is set, slots 1 to 31 behave as in R8. Slot 0, the framing slot, follows its own per-slot word.
- R11: Any active global mode overrides the per-slot bits of the slots it covers. When several global bits are set, the highest-numbered bit wins, in the order 3, 2, 1, 0.
- R12: A register write in the same cycle as a slot strobe does not affect that slot. It takes effect from the next strobe.
- R13: `out_valid` is high exactly one clock after each strobe. On cycles with no strobe, `sys_rx_byte`, `line_tx_byte` and `out_slot` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 6 | Register address: 0-31 per-slot words, 32 global |
| reg_wdata | input | 8 | Register write data |
| slot_valid | input | 1 | Slot strobe |
| slot_idx | input | 5 | Index of the strobed slot |
| sys_tx_byte | input | 8 | Byte from the system side, headed for the line |
| line_rx_byte | input | 8 | Byte received from the line |
| out_valid | output | 1 | Outputs updated by a strobe |
| out_slot | output | 5 | Slot index of the current outputs |
| sys_rx_byte | output | 8 | Byte toward the system output |
| line_tx_byte | output | 8 | Byte toward the line |

## Verification
Every routed byte, and the echoed slot index, is registered once. The bench drives a strobe on a falling edge and reads all outputs at the next falling edge, one clock later. A register write takes effect on the clock edge that ends its cycle, so the bench's reference model applies each write only after it has computed the expected value for a strobe in the same cycle. That ordering is exactly what R12 checks. For the hold behaviour, the bench leaves one cycle without a strobe and compares the outputs with the values from the previous slot.

// File: rtl/tslot_loop_pkg.sv
package tslot_loop_pkg;

    localparam int NUM_SLOTS   = 32;
    localparam int BYTE_W      = 8;
    localparam int SLOT_W      = $clog2(NUM_SLOTS);
    localparam int ADDR_W      = SLOT_W + 1;
    localparam int LOCAL_BIT   = 5;
    localparam int REMOTE_BIT  = 4;
    localparam int GLOBAL_ADDR = NUM_SLOTS;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = '1;

    // Per-slot loop choice
    typedef struct packed {
        logic loc;
        logic rem;
    } slot_cfg_t;

    // Global modes, MSB first so the packed order matches bits 3..0
    typedef struct packed {
        logic digital;
        logic remote;
        logic sysbus;
        logic payload;
    } glb_cfg_t;

    typedef enum logic {
        SYS_FROM_LINE = 1'b0,
        SYS_FROM_TX   = 1'b1
    } sys_src_e;

    typedef enum logic [1:0] {
        LINE_FROM_SYS  = 2'd0,
        LINE_FROM_RX   = 2'd1,
        LINE_FROM_IDLE = 2'd2
    } line_src_e;

    typedef struct packed {
        sys_src_e  sys_src;
        line_src_e line_src;
    } route_t;

    function automatic route_t pick_route(glb_cfg_t g, slot_cfg_t s, logic framing_slot);
        route_t r;
        if (g.digital) begin
            r.sys_src  = SYS_FROM_TX;
            r.line_src = LINE_FROM_SYS;
        end else if (g.remote) begin
            r.sys_src  = SYS_FROM_LINE;
            r.line_src = LINE_FROM_RX;
        end else if (g.sysbus) begin
            r.sys_src  = SYS_FROM_TX;
            r.line_src = LINE_FROM_IDLE;
        end else if (g.payload && !framing_slot) begin
            r.sys_src  = SYS_FROM_LINE;
            r.line_src = LINE_FROM_RX;
        end else begin
            r.sys_src  = s.loc ? SYS_FROM_TX  : SYS_FROM_LINE;
            r.line_src = s.rem ? LINE_FROM_RX : LINE_FROM_SYS;
        end
        return r;
    endfunction

endpackage

// File: rtl/tslot_loop_regs.sv
module tslot_loop_regs
    import tslot_loop_pkg::*;
#(
    parameter int SLOTS  = NUM_SLOTS,
    parameter int DW     = BYTE_W,
    localparam int SW    = $clog2(SLOTS),
    localparam int AW    = SW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] rd_idx,
    output slot_cfg_t     slot_cfg_o,
    output glb_cfg_t      glb_cfg_o
);

    slot_cfg_t slot_cfg_q [SLOTS];
    glb_cfg_t  glb_q;

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^{wdata[DW-1:LOCAL_BIT+1]};

    genvar gi;
    generate
        for (gi = 0; gi < SLOTS; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_cfg_q[gi] <= '0;
                end else if (we && addr == AW'(gi)) begin
                    slot_cfg_q[gi].loc <= wdata[LOCAL_BIT];
                    slot_cfg_q[gi].rem <= wdata[REMOTE_BIT];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_q <= '0;
        end else if (we && addr == AW'(SLOTS)) begin
            glb_q <= glb_cfg_t'(wdata[3:0]);
        end
    end

    assign slot_cfg_o = slot_cfg_q[rd_idx];
    assign glb_cfg_o  = glb_q;

    // R1
    reset_clears_global_chk: assert property (@(posedge clk)
        rst |=> (glb_q == '0));

endmodule

// File: rtl/tslot_loop_route.sv
module tslot_loop_route
    import tslot_loop_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS,
    localparam int SW   = $clog2(SLOTS)
) (
    input  glb_cfg_t      glb_cfg,
    input  slot_cfg_t     slot_cfg,
    input  logic [SW-1:0] slot_idx,
    output route_t        route
);

    always_comb begin
        route = pick_route(glb_cfg, slot_cfg, slot_idx == '0);
    end

endmodule

// File: rtl/tslot_loop_outstage.sv
module tslot_loop_outstage
    import tslot_loop_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS,
    parameter int DW    = BYTE_W,
    parameter logic [DW-1:0] IDLE = IDLE_BYTE,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic [SW-1:0] idx,
    input  route_t        route,
    input  logic [DW-1:0] tx_in,
    input  logic [DW-1:0] rx_in,
    output logic          valid_q,
    output logic [SW-1:0] idx_q,
    output logic [DW-1:0] sys_q,
    output logic [DW-1:0] line_q
);

    logic [DW-1:0] sys_d;
    logic [DW-1:0] line_d;

    always_comb begin
        sys_d = (route.sys_src == SYS_FROM_TX) ? tx_in : rx_in;
        unique case (route.line_src)
            LINE_FROM_RX:   line_d = rx_in;
            LINE_FROM_IDLE: line_d = IDLE;
            default:        line_d = tx_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
            sys_q   <= '0;
            line_q  <= '0;
        end else begin
            valid_q <= strobe;
            if (strobe) begin
                idx_q  <= idx;
                sys_q  <= sys_d;
                line_q <= line_d;
            end
        end
    end

    // R13
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> ($stable(sys_q) && $stable(line_q) && $stable(idx_q)));

endmodule

// File: rtl/tslot_loop_switch.sv
module tslot_loop_switch
    import tslot_loop_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS,
    parameter int DW    = BYTE_W,
    localparam int SW   = $clog2(SLOTS),
    localparam int AW   = SW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          slot_valid,
    input  logic [SW-1:0] slot_idx,
    input  logic [DW-1:0] sys_tx_byte,
    input  logic [DW-1:0] line_rx_byte,
    output logic          out_valid,
    output logic [SW-1:0] out_slot,
    output logic [DW-1:0] sys_rx_byte,
    output logic [DW-1:0] line_tx_byte
);

    slot_cfg_t cur_slot_cfg;
    glb_cfg_t  cur_glb;
    route_t    cur_route;

    tslot_loop_regs #(.SLOTS(SLOTS), .DW(DW)) i_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rd_idx     (slot_idx),
        .slot_cfg_o (cur_slot_cfg),
        .glb_cfg_o  (cur_glb)
    );

    tslot_loop_route #(.SLOTS(SLOTS)) i_route (
        .glb_cfg  (cur_glb),
        .slot_cfg (cur_slot_cfg),
        .slot_idx (slot_idx),
        .route    (cur_route)
    );

    tslot_loop_outstage #(.SLOTS(SLOTS), .DW(DW)) i_out (
        .clk     (clk),
        .rst     (rst),
        .strobe  (slot_valid),
        .idx     (slot_idx),
        .route   (cur_route),
        .tx_in   (sys_tx_byte),
        .rx_in   (line_rx_byte),
        .valid_q (out_valid),
        .idx_q   (out_slot),
        .sys_q   (sys_rx_byte),
        .line_q  (line_tx_byte)
    );

    // R13
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        slot_valid |=> out_valid);

    // R13
    valid_low_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_valid |=> !out_valid);

    // R7
    digital_loop_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && cur_glb.digital) |=>
            (sys_rx_byte == $past(sys_tx_byte) && line_tx_byte == $past(sys_tx_byte)));

    // R8
    global_remote_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && !cur_glb.digital && cur_glb.remote) |=>
            (line_tx_byte == $past(line_rx_byte) && sys_rx_byte == $past(line_rx_byte)));

    // R4
    slot_remote_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && cur_glb == '0 && cur_slot_cfg.rem) |=>
            (line_tx_byte == $past(line_rx_byte)));

    // R3
    slot_local_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && cur_glb == '0 && cur_slot_cfg.loc) |=>
            (sys_rx_byte == $past(sys_tx_byte)));

endmodule

// File: tb/test_tslot_loop_switch.sv
module test_tslot_loop_switch;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_we;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       slot_valid;
    logic [4:0] slot_idx;
    logic [7:0] sys_tx_byte;
    logic [7:0] line_rx_byte;
    logic       out_valid;
    logic [4:0] out_slot;
    logic [7:0] sys_rx_byte;
    logic [7:0] line_tx_byte;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic       m_loc [32];
    logic       m_rem [32];
    logic [3:0] m_glb;
    logic [7:0] last_sys;
    logic [7:0] last_line;
    logic [4:0] last_slot;

    always #4 clk = ~clk;

    tslot_loop_switch i_tslot_loop_switch (
        .clk          (clk),
        .rst          (rst),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .slot_valid   (slot_valid),
        .slot_idx     (slot_idx),
        .sys_tx_byte  (sys_tx_byte),
        .line_rx_byte (line_rx_byte),
        .out_valid    (out_valid),
        .out_slot     (out_slot),
        .sys_rx_byte  (sys_rx_byte),
        .line_tx_byte (line_tx_byte)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected bytes from the requirements: digital > remote > sysbus > payload > per-slot
    function automatic logic [15:0] expect_bytes(input logic [4:0] idx, input logic [7:0] tx,
                                                 input logic [7:0] rx);
        logic [7:0] s;
        logic [7:0] l;
        if (m_glb[3]) begin
            s = tx; l = tx;
        end else if (m_glb[2]) begin
            s = rx; l = rx;
        end else if (m_glb[1]) begin
            s = tx; l = 8'hFF;
        end else if (m_glb[0] && idx != 5'd0) begin
            s = rx; l = rx;
        end else begin
            s = m_loc[idx] ? tx : rx;
            l = m_rem[idx] ? rx : tx;
        end
        return {s, l};
    endfunction

    task automatic cycle(input logic we, input logic [5:0] a, input logic [7:0] d,
                         input logic v, input logic [4:0] idx, input logic [7:0] tx,
                         input logic [7:0] rx, input string req);
        logic [15:0] e;
        e = expect_bytes(idx, tx, rx);
        reg_we = we; reg_addr = a; reg_wdata = d;
        slot_valid = v; slot_idx = idx; sys_tx_byte = tx; line_rx_byte = rx;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; slot_valid = 1'b0;
        if (we) begin
            if (a < 6'd32) begin
                m_loc[a[4:0]] = d[5];
                m_rem[a[4:0]] = d[4];
            end else if (a == 6'd32) begin
                m_glb = d[3:0];
            end
        end
        if (v) begin
            check(req, "out_valid", int'(out_valid), 1);
            check(req, "out_slot", int'(out_slot), int'(idx));
            check(req, "sys_rx_byte", int'(sys_rx_byte), int'(e[15:8]));
            check(req, "line_tx_byte", int'(line_tx_byte), int'(e[7:0]));
            last_sys = e[15:8]; last_line = e[7:0]; last_slot = idx;
        end else begin
            check(req, "out_valid idle", int'(out_valid), 0);
            check(req, "sys_rx_byte hold", int'(sys_rx_byte), int'(last_sys));
            check(req, "line_tx_byte hold", int'(line_tx_byte), int'(last_line));
            check(req, "out_slot hold", int'(out_slot), int'(last_slot));
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d, input string req);
        cycle(1'b1, a, d, 1'b0, 5'd0, 8'h00, 8'h00, req);
    endtask

    task automatic slot(input logic [4:0] idx, input logic [7:0] tx, input logic [7:0] rx,
                        input string req);
        cycle(1'b0, 6'd0, 8'h00, 1'b1, idx, tx, rx, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) begin
            m_loc[i] = 1'b0;
            m_rem[i] = 1'b0;
        end
        m_glb = 4'h0;
        last_sys = 8'h00; last_line = 8'h00; last_slot = 5'd0;
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        slot_valid = 1'b0; slot_idx = '0; sys_tx_byte = '0; line_rx_byte = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "sys_rx_byte", int'(sys_rx_byte), 0);
        check("R1", "line_tx_byte", int'(line_tx_byte), 0);
        slot(5'd3, 8'hA1, 8'h5E, "R1");
        // R2 plain pass-through
        slot(5'd31, 8'h12, 8'h34, "R2");
        // R3 local loop, bit 5
        wr(6'd5, 8'h20, "R3");
        slot(5'd5, 8'hC3, 8'h3C, "R3");
        slot(5'd6, 8'hC3, 8'h3C, "R3");
        // R4 remote loop, bit 4
        wr(6'd7, 8'h10, "R4");
        slot(5'd7, 8'h99, 8'h66, "R4");
        // R5 both loops
        wr(6'd9, 8'h30, "R5");
        slot(5'd9, 8'h0F, 8'hF0, "R5");
        // R6 other bits and unused addresses ignored
        wr(6'd11, 8'hCF, "R6");
        slot(5'd11, 8'h77, 8'h88, "R6");
        wr(6'd40, 8'hFF, "R6");
        wr(6'd63, 8'h3F, "R6");
        slot(5'd2, 8'h11, 8'h22, "R6");
        // R13 hold on idle cycle
        cycle(1'b0, 6'd0, 8'h00, 1'b0, 5'd0, 8'h00, 8'h00, "R13");
        // R7 digital
        wr(6'd32, 8'h08, "R7");
        slot(5'd9, 8'hAB, 8'hCD, "R7");
        // R8 remote global, overrides local of slot 5 (R11)
        wr(6'd32, 8'h04, "R8");
        slot(5'd5, 8'h13, 8'h57, "R8");
        slot(5'd0, 8'h24, 8'h68, "R11");
        // R9 system-bus loop
        wr(6'd32, 8'h02, "R9");
        slot(5'd7, 8'h5A, 8'hA5, "R9");
        // R10 payload loop, slot 0 keeps per-slot word
        wr(6'd0, 8'h20, "R10");
        wr(6'd32, 8'h01, "R10");
        slot(5'd0, 8'h31, 8'h42, "R10");
        slot(5'd12, 8'h31, 8'h42, "R10");
        // R11 highest global bit wins
        wr(6'd32, 8'h0F, "R11");
        slot(5'd4, 8'hE1, 8'h1E, "R11");
        wr(6'd32, 8'h07, "R11");
        slot(5'd4, 8'hE1, 8'h1E, "R11");
        wr(6'd32, 8'h00, "R11");
        // R12 write in the strobe cycle applies from next strobe
        cycle(1'b1, 6'd13, 8'h20, 1'b1, 5'd13, 8'hBE, 8'hEF, "R12");
        slot(5'd13, 8'hBE, 8'hEF, "R12");
        cycle(1'b1, 6'd32, 8'h08, 1'b1, 5'd14, 8'h01, 8'h02, "R12");
        slot(5'd14, 8'h01, 8'h02, "R12");
        wr(6'd32, 8'h00, "R12");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned pick;
            pick = $urandom % 10;
            if (pick < 2) begin
                logic [5:0] a;
                a = ($urandom % 4 == 0) ? 6'd32 : 6'($urandom);
                if (a == 6'd32 && ($urandom % 2 == 0)) begin
                    wr(a, 8'h00, "R11");
                end else begin
                    wr(a, 8'($urandom), "R6");
                end
            end else if (pick < 3) begin
                cycle(1'b0, 6'd0, 8'h00, 1'b0, 5'd0, 8'h00, 8'h00, "R13");
            end else if (pick < 4) begin
                cycle(1'b1, 6'($urandom % 33), 8'($urandom), 1'b1, 5'($urandom),
                      8'($urandom), 8'($urandom), "R12");
            end else begin
                slot(5'($urandom), 8'($urandom), 8'($urandom), "R5");
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule